// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps wall-clock time as one 47-bit count that advances by one on every pulse of a slow time-base strobe (nominally 32.768 kHz, brought in as a single-cycle strobe in the fast clock domain). The upper 32 bits are whole seconds. The lower 15 bits are the sub-second fraction. A 32-bit alarm value is compared against the seconds each time the fraction rolls over. A match raises a sticky alarm flag, and that flag drives an interrupt when enabled.

Counting halts when software clears the enable bit, when the count has wrapped, or when the surrounding security logic reports a non-valid or failure condition. A halted counter keeps the time at which it stopped. Soft and hard lock inputs from the lock logic protect the time registers against writes. Loading the seconds word also sets the enable bit, so a fresh time write starts the clock. All register writes share one port with a select code. Read values are presented continuously on outputs. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `sec_alarm_counter`

## Requirements
- R1: While running, each cycle with `tick_i` high adds one to the 47-bit value {`sec_o`,`frac_o`}, so a fraction of 0x7FFF carries into the seconds word; in cycles without a tick the value holds.
- R2: The counter is running only when `enable_o` is 1, `ovf_o` is 0, `non_valid_i` is 0 and `failure_i` is 0; otherwise ticks leave seconds and fraction unchanged.
- R3: A tick taken at the all-ones value wraps the count to zero and sets `ovf_o`; a status write (select 4) with data bit 0 set clears it, and the same write with bit 0 clear leaves it set.
- R4: While `lock_soft_i` or `lock_hard_i` is high, writes with select 0 (seconds), 1 (fraction) and 3 (control) are ignored.
- R5: A seconds write (select 0) loads `sec_o` and sets `enable_o`; a fraction write (select 1) loads `frac_o` from data bits 14:0; a control write (select 3) sets `enable_o` to data bit 0.
- R6: `alarm_flag_o` is set one cycle after a tick rolls the fraction to zero with the new seconds equal to `alarm_o`; loading the seconds to the alarm value directly does not set it.
- R7: An alarm value of all ones (0xFFFFFFFF) never sets the alarm flag, even when the seconds pass through that value.
- R8: A status write with data bit 1 set clears `alarm_flag_o`; if a match occurs in the same cycle, the flag stays set.
- R9: `alarm_irq_o` is high exactly when `alarm_flag_o` and `alarm_ie_i` are both high.
- R10: After reset, seconds, fraction, enable, overflow and alarm flag are all zero and the alarm register holds all ones.
- R11: An accepted seconds or fraction write in the same cycle as a tick takes precedence, and the tick is dropped.
- R12: Select 2 loads `alarm_o` regardless of the lock inputs; select codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time-base strobe |
| non_valid_i | input | 1 | Non-valid condition from the security logic; halts counting |
| failure_i | input | 1 | Failure condition from the security logic; halts counting |
| lock_soft_i | input | 1 | Soft write protection for the time registers |
| lock_hard_i | input | 1 | Hard write protection for the time registers |
| alarm_ie_i | input | 1 | Alarm interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target: 0 seconds, 1 fraction, 2 alarm, 3 control, 4 status clear |
| wr_data_i | input | 32 | Write data |
| sec_o | output | 32 | Seconds word |
| frac_o | output | 15 | Fraction word |
| alarm_o | output | 32 | Alarm seconds value |
| enable_o | output | 1 | Counter enable bit |
| ovf_o | output | 1 | Overflow flag |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume that every input is a known value, settled before each rising edge. They also assume that a write and a tick in the same cycle are resolved inside the block rather than prevented by the caller. The stimulus changes inputs only on the falling edge. It deliberately overlaps writes with ticks, locks with counter writes, and status clears with alarm matches, so that the precedence rules are exercised and not avoided. Random seconds and alarm values are drawn close to each other, and fractions close to 0x7FFF, so that rollovers and matches happen often within a short run.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_FRAC  = 3'd1,
    SEL_ALARM = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_STAT  = 3'd4
  } sac_sel_e;

  localparam int STAT_OVF_BIT = 0;
  localparam int STAT_ALM_BIT = 1;
  localparam int CTRL_EN_BIT  = 0;
endpackage

// File: rtl/sac_counter.sv
module sac_counter
  import sac_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              halt_ext,
  input  logic              ld_sec,
  input  logic              ld_frac,
  input  logic              ld_en,
  input  logic              ovf_clr,
  input  logic [SEC_W-1:0]  wdata,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic              en_q,
  output logic              ovf_q,
  output logic              boundary_o,
  output logic [SEC_W-1:0]  sec_next_o
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic running, step, wrap;

  assign running    = en_q & ~ovf_q & ~halt_ext;
  assign step       = tick & running & ~ld_sec & ~ld_frac;
  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign wrap       = step & (&cnt_q);
  assign boundary_o = step & (&cnt_q[FRAC_W-1:0]);
  assign sec_next_o = cnt_inc[CNT_W-1:FRAC_W];
  assign sec_q      = cnt_q[CNT_W-1:FRAC_W];
  assign frac_q     = cnt_q[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (step)    cnt_q <= cnt_inc;
      if (ld_sec)  cnt_q[CNT_W-1:FRAC_W] <= wdata;
      if (ld_frac) cnt_q[FRAC_W-1:0] <= wdata[FRAC_W-1:0];
      if (ld_sec)     en_q <= 1'b1;
      else if (ld_en) en_q <= wdata[CTRL_EN_BIT];
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step && !(&cnt_q) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !ld_sec && !ld_frac |=> $stable(cnt_q));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && (&cnt_q) |=> ovf_q && cnt_q == '0);

  assert_tick_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sec && !ld_frac |=> frac_q == $past(frac_q));
endmodule

// File: rtl/sac_alarm.sv
module sac_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_alarm,
  input  logic [SEC_W-1:0] wdata,
  input  logic             boundary,
  input  logic [SEC_W-1:0] sec_next,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic [SEC_W-1:0] alarm_q,
  output logic             flag_q,
  output logic             irq_o
);
  localparam logic [SEC_W-1:0] UNUSED_VAL = '1;

  logic armed, hit;

  assign armed = (alarm_q != UNUSED_VAL);
  assign hit   = boundary & armed & (sec_next == alarm_q);
  assign irq_o = flag_q & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= UNUSED_VAL;
      flag_q  <= 1'b0;
    end else begin
      if (ld_alarm) alarm_q <= wdata;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assert_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q == UNUSED_VAL) && !flag_q |=> !flag_q);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && flag_clr && !boundary |=> !flag_q);

  assert_no_match_off_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !boundary |=> !flag_q);
endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter
  import sac_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              non_valid_i,
  input  logic              failure_i,
  input  logic              lock_soft_i,
  input  logic              lock_hard_i,
  input  logic              alarm_ie_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [SEC_W-1:0]  wr_data_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SEC_W-1:0]  alarm_o,
  output logic              enable_o,
  output logic              ovf_o,
  output logic              alarm_flag_o,
  output logic              alarm_irq_o
);
  sac_sel_e sel;
  logic locked;
  logic ld_sec, ld_frac, ld_en, ld_alarm, ovf_clr, flag_clr;
  logic boundary;
  logic [SEC_W-1:0] sec_next;

  assign sel      = sac_sel_e'(wr_sel_i);
  assign locked   = lock_soft_i | lock_hard_i;
  assign ld_sec   = wr_en_i & ~locked & (sel == SEL_SEC);
  assign ld_frac  = wr_en_i & ~locked & (sel == SEL_FRAC);
  assign ld_en    = wr_en_i & ~locked & (sel == SEL_CTRL);
  assign ld_alarm = wr_en_i & (sel == SEL_ALARM);
  assign ovf_clr  = wr_en_i & (sel == SEL_STAT) & wr_data_i[STAT_OVF_BIT];
  assign flag_clr = wr_en_i & (sel == SEL_STAT) & wr_data_i[STAT_ALM_BIT];

  sac_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_i),
    .halt_ext   (non_valid_i | failure_i),
    .ld_sec     (ld_sec),
    .ld_frac    (ld_frac),
    .ld_en      (ld_en),
    .ovf_clr    (ovf_clr),
    .wdata      (wr_data_i),
    .sec_q      (sec_o),
    .frac_q     (frac_o),
    .en_q       (enable_o),
    .ovf_q      (ovf_o),
    .boundary_o (boundary),
    .sec_next_o (sec_next)
  );

  sac_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_alarm (ld_alarm),
    .wdata    (wr_data_i),
    .boundary (boundary),
    .sec_next (sec_next),
    .flag_clr (flag_clr),
    .irq_en   (alarm_ie_i),
    .alarm_q  (alarm_o),
    .flag_q   (alarm_flag_o),
    .irq_o    (alarm_irq_o)
  );

  assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !tick_i |=> $stable(sec_o) && $stable(frac_o) && $stable(enable_o));

  assert_sec_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !locked && sel == SEL_SEC |=> enable_o && sec_o == $past(wr_data_i));
endmodule

// File: tb/sec_alarm_counter_test.sv
module sec_alarm_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, non_valid = 0, failure = 0, lock_soft = 0, lock_hard = 0, alarm_ie = 0;
  logic wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] sec_o, alarm_o;
  logic [14:0] frac_o;
  logic enable_o, ovf_o, alarm_flag_o, alarm_irq_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_sec, m_alarm;
  logic [14:0] m_frac;
  logic m_en, m_ovf, m_flag;

  always #2 clk = ~clk;

  sec_alarm_counter uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .non_valid_i(non_valid),
    .failure_i(failure), .lock_soft_i(lock_soft), .lock_hard_i(lock_hard),
    .alarm_ie_i(alarm_ie), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec_o), .frac_o(frac_o), .alarm_o(alarm_o), .enable_o(enable_o),
    .ovf_o(ovf_o), .alarm_flag_o(alarm_flag_o), .alarm_irq_o(alarm_irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [46:0] next_count(input logic [46:0] c);
    return c + 47'd1;
  endfunction

  function automatic bit is_match(input logic [46:0] c, input logic [31:0] alm);
    return (c[14:0] == 15'd0) && (alm != 32'hFFFF_FFFF) && (c[46:15] == alm);
  endfunction

  task automatic model_step();
    logic [46:0] c;
    bit locked, ldc, run, stp, set_o, set_a;
    logic [31:0] old_alarm;
    locked = lock_soft | lock_hard;
    ldc = wr_en && !locked && (wr_sel == 3'd0 || wr_sel == 3'd1);
    run = m_en && !m_ovf && !non_valid && !failure;
    stp = tick && run && !ldc;
    c = {m_sec, m_frac};
    old_alarm = m_alarm;
    set_o = 0; set_a = 0;
    if (stp) begin
      if (&c) set_o = 1;
      c = next_count(c);
      set_a = is_match(c, old_alarm);
    end
    if (wr_en) begin
      case (wr_sel)
        3'd0: if (!locked) begin c[46:15] = wr_data; m_en = 1'b1; end
        3'd1: if (!locked) c[14:0] = wr_data[14:0];
        3'd2: m_alarm = wr_data;
        3'd3: if (!locked) m_en = wr_data[0];
        3'd4: begin
          if (wr_data[0]) m_ovf = 1'b0;
          if (wr_data[1]) m_flag = 1'b0;
        end
        default: ;
      endcase
    end
    if (set_o) m_ovf = 1'b1;
    if (set_a) m_flag = 1'b1;
    m_sec = c[46:15];
    m_frac = c[14:0];
  endtask

  task automatic compare_all();
    check(sec_o == m_sec, "R1 seconds", 64'(sec_o), 64'(m_sec));
    check(frac_o == m_frac, "R1 fraction", 64'(frac_o), 64'(m_frac));
    check(alarm_o == m_alarm, "R12 alarm reg", 64'(alarm_o), 64'(m_alarm));
    check(enable_o == m_en, "R5 enable", 64'(enable_o), 64'(m_en));
    check(ovf_o == m_ovf, "R3 overflow", 64'(ovf_o), 64'(m_ovf));
    check(alarm_flag_o == m_flag, "R6 alarm flag", 64'(alarm_flag_o), 64'(m_flag));
    check(alarm_irq_o == (m_flag & alarm_ie), "R9 irq", 64'(alarm_irq_o), 64'(m_flag & alarm_ie));
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic write(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    cycle();
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cycle();
      tick = 0; cycle();
    end
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sec = 0; m_frac = 0; m_alarm = 32'hFFFF_FFFF; m_en = 0; m_ovf = 0; m_flag = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R10 reset state
    check(sec_o == 0 && frac_o == 0 && enable_o == 0 && ovf_o == 0 && alarm_flag_o == 0,
          "R10 reset zeros", 64'({sec_o, frac_o, enable_o, ovf_o, alarm_flag_o}), 64'd0);
    check(alarm_o == 32'hFFFF_FFFF, "R10 alarm reset", 64'(alarm_o), 64'hFFFF_FFFF);
    rst_n = 1;
    cycle();

    // R2: disabled counter ignores ticks
    ticks(3);
    check(frac_o == 0, "R2 disabled holds", 64'(frac_o), 64'd0);

    // R5 loads, R6 match on rollover
    write(3'd1, 32'h0000_7FFE);
    check(frac_o == 15'h7FFE && enable_o == 0, "R5 fraction load", 64'(frac_o), 64'h7FFE);
    write(3'd0, 32'd10);
    check(sec_o == 10 && enable_o == 1, "R5 seconds load sets enable", 64'({sec_o, enable_o}), 64'({32'd10, 1'b1}));
    write(3'd2, 32'd11);
    alarm_ie = 1;
    ticks(1);
    check(alarm_flag_o == 0, "R6 no flag before boundary", 64'(alarm_flag_o), 64'd0);
    ticks(1);
    check(sec_o == 11 && frac_o == 0, "R1 carry into seconds", 64'({sec_o, frac_o}), 64'({32'd11, 15'd0}));
    check(alarm_flag_o == 1 && alarm_irq_o == 1, "R6 R9 flag and irq", 64'({alarm_flag_o, alarm_irq_o}), 64'd3);
    alarm_ie = 0; cycle();
    check(alarm_irq_o == 0, "R9 irq masked", 64'(alarm_irq_o), 64'd0);

    // R8 clear
    write(3'd4, 32'd2);
    check(alarm_flag_o == 0, "R8 flag cleared", 64'(alarm_flag_o), 64'd1 - 64'd1);

    // R6 direct load equal to alarm does not match
    write(3'd0, 32'd11);
    write(3'd1, 32'd5);
    ticks(2);
    check(alarm_flag_o == 0, "R6 load equal no match", 64'(alarm_flag_o), 64'd0);

    // R4 locks
    lock_soft = 1; write(3'd0, 32'd99);
    check(sec_o == 11, "R4 soft lock seconds", 64'(sec_o), 64'd11);
    lock_soft = 0; lock_hard = 1; write(3'd3, 32'd0);
    check(enable_o == 1, "R4 hard lock control", 64'(enable_o), 64'd1);
    write(3'd2, 32'd500);
    check(alarm_o == 500, "R12 alarm ignores lock", 64'(alarm_o), 64'd500);
    lock_hard = 0;
    write(3'd6, 32'hFFFF_FFFF);
    check(sec_o == 11 && alarm_o == 500 && enable_o == 1, "R12 unused select", 64'(sec_o), 64'd11);

    // R2 halts
    non_valid = 1; ticks(2);
    check(frac_o == 7, "R2 non-valid holds", 64'(frac_o), 64'd7);
    non_valid = 0; failure = 1; ticks(2);
    check(frac_o == 7, "R2 failure holds", 64'(frac_o), 64'd7);
    failure = 0; write(3'd3, 32'd0); ticks(2);
    check(frac_o == 7 && enable_o == 0, "R2 enable clear holds", 64'(frac_o), 64'd7);

    // R7 unused alarm at all-ones seconds
    write(3'd2, 32'hFFFF_FFFF);
    write(3'd0, 32'hFFFF_FFFE);
    write(3'd1, 32'h7FFF);
    ticks(1);
    check(sec_o == 32'hFFFF_FFFF && alarm_flag_o == 0, "R7 unused alarm", 64'(alarm_flag_o), 64'd0);

    // R3 wrap
    write(3'd1, 32'h7FFF);
    ticks(1);
    check(sec_o == 0 && frac_o == 0 && ovf_o == 1, "R3 wrap sets overflow", 64'({sec_o, frac_o, ovf_o}), 64'd1);
    ticks(2);
    check(frac_o == 0, "R2 overflow halts", 64'(frac_o), 64'd0);
    write(3'd4, 32'd2);
    check(ovf_o == 1, "R3 zero bit leaves overflow", 64'(ovf_o), 64'd1);
    write(3'd4, 32'd1);
    check(ovf_o == 0, "R3 overflow cleared", 64'(ovf_o), 64'd0);

    // R11 write beats tick
    write(3'd1, 32'd20);
    tick = 1; write(3'd0, 32'd40); tick = 0;
    check(frac_o == 20 && sec_o == 40, "R11 tick dropped", 64'(frac_o), 64'd20);

    // R8 set wins over clear
    write(3'd2, 32'd41);
    write(3'd1, 32'h7FFF);
    tick = 1; write(3'd4, 32'd2); tick = 0;
    check(alarm_flag_o == 1, "R8 set wins", 64'(alarm_flag_o), 64'd1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      tick      = ($urandom % 2) == 0;
      non_valid = ($urandom % 12) == 0;
      failure   = ($urandom % 12) == 0;
      lock_soft = ($urandom % 10) == 0;
      lock_hard = ($urandom % 10) == 0;
      alarm_ie  = ($urandom % 3) != 0;
      wr_en     = ($urandom % 6) == 0;
      wr_sel    = 3'($urandom % 8);
      case (wr_sel)
        3'd0: wr_data = (($urandom % 4) == 0) ? 32'hFFFF_FFFF - ($urandom % 3) : m_alarm - ($urandom % 3);
        3'd1: wr_data = 32'h7FFF - ($urandom % 6);
        3'd2: wr_data = (($urandom % 8) == 0) ? 32'hFFFF_FFFF : m_sec + ($urandom % 3);
        3'd3: wr_data = (($urandom % 5) == 0) ? 32'd0 : 32'd1;
        default: wr_data = $urandom;
      endcase
      if (wr_sel == 3'd4 && ($urandom % 2) == 0) wr_data = 32'd0;
      cycle();
    end
    wr_en = 0; tick = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule